// File: doc/BRIEF.md
# UART Control Register Bank

This block is the software-facing side of a simple serial port. A 32-bit register bus with word-only accesses reaches a 1 KiB window. Behind it sit a byte-wide transmit queue, a one-byte receive holding register, a control word that gates each direction, and four interrupt lines. Software writes bytes into the queue. A downstream bit serializer takes them one per `tx_ready` pulse, and only while transmit is enabled. Received bytes arrive as a single-cycle strobe from the deserializer and wait in the holding register until software reads them.

Each interrupt source has a sticky state bit, set by a hardware event, cleared when software writes a 1 to it, and forced when software writes a 1 into the test word. An enable bit gates each source onto its own output line. The transmit queue raises a watermark event when its fill reaches a programmed threshold and lowers it as draining takes the fill below that threshold. It raises an empty event when draining empties it. A push into a full queue is dropped and leaves a sticky overflow flag in the status word.

Top module: `uart_regbank`

## Requirements
- R1: Interrupt bit order is [0] tx watermark, [1] rx watermark, [2] tx empty, [3] rx overflow, in the state, enable and test words. Each output line is high exactly when its state bit and its enable bit are both set.
- R2: Word map by byte offset: 0x00 interrupt state, 0x04 interrupt enable, 0x08 interrupt test, 0x0C control, 0x10 status, 0x14 receive data, 0x18 transmit data, 0x1C queue control, 0x20 queue status. Writing 1s to offset 0x00 clears those state bits. Writing 1s to 0x08 sets them.
- R3: After reset every readable word is zero except status, which reads 0x3C. Status bits are [0] tx full, [1] rx holding full, [2] tx empty, [3] tx idle, [4] rx idle, [5] rx empty, [6] tx overflow.
- R4: A write to 0x18 appends bits [7:0] to the transmit queue of 32 entries. When the queue is full the byte is dropped, the fill stays at 32 and status bit 6 becomes set.
- R5: Queue control bits [6:4] pick the watermark threshold: code c gives 2^c for c up to 4, and 16 for codes 5 to 7. A push that brings the fill to or above the threshold sets the tx watermark state bit. A drain that takes the fill below it clears that bit.
- R6: Status bit 0 is set while the fill equals 32. Status bits 2 and 3 are set while the fill is zero. A drain that empties the queue sets the tx empty state bit.
- R7: Writing queue control with bit 1 set empties the transmit queue at once and clears status bit 6.
- R8: Reading offset 0x20 returns the current transmit fill in bits [5:0].
- R9: With control bit 1 (receive enable) set, an `rx_valid` strobe loads `rx_byte` into the holding register, clears status bits 4 and 5, and sets the rx watermark state bit. It also sets the rx overflow state bit if the previous byte had not been read. With receive disabled the strobe has no effect.
- R10: A read of offset 0x14 returns the held byte. It sets status bits 4 and 5 only when receive is enabled.
- R11: With control bit 0 (transmit enable) set, each `tx_ready` pulse removes one byte from a non-empty queue in arrival order, and `tx_data` shows the oldest byte. With transmit disabled the fill never drops, except through R7.
- R12: Writes to the status, receive data and queue status words, writes to unmapped or misaligned addresses, and reads of write-only or unmapped words change nothing, and such reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 10 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Serializer takes one byte |
| tx_data | output | 8 | Oldest queued byte |
| tx_avail | output | 1 | Queue non-empty and transmit enabled |
| irq_tx_wm | output | 1 | Transmit watermark interrupt |
| irq_rx_wm | output | 1 | Receive watermark interrupt |
| irq_tx_empty | output | 1 | Transmit empty interrupt |
| irq_rx_ovf | output | 1 | Receive overflow interrupt |

## Verification
The properties assume that `bus_req` is a single-cycle strobe with its address held stable, and that `tx_ready` and `rx_valid` are single-cycle pulses that may arrive at any time relative to bus traffic. The drain property assumes that only a queue-control reset lowers the fill while transmit is disabled, and it excludes that write by name. The stimulus drives every input at the falling clock edge and pulses each strobe for one cycle, so every bus access, drain and receive event falls on exactly one rising edge.

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter int DEPTH = 32,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_avail,
  output logic          irq_tx_wm,
  output logic          irq_rx_wm,
  output logic          irq_tx_empty,
  output logic          irq_rx_ovf
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int WW = AW - 2;
  localparam logic [WW-1:0] W_STATE = WW'(0), W_EN = WW'(1), W_TEST = WW'(2),
                            W_CTRL = WW'(3), W_STAT = WW'(4), W_RDAT = WW'(5),
                            W_WDAT = WW'(6), W_FCTL = WW'(7), W_FSTAT = WW'(8);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [LW-1:0] level, lvl_next, thr;
  logic [3:0]    int_st, int_en, events, clr, tst;
  logic          tx_en, rx_en, tx_ovf, rx_empty, rx_idle;
  logic [2:0]    thr_code;
  logic [7:0]    rx_data;

  wire [WW-1:0] widx    = bus_addr[AW-1:2];
  wire          aligned = (bus_addr[1:0] == 2'b00);
  wire          wr      = bus_req & bus_we & aligned;
  wire          rd      = bus_req & ~bus_we & aligned;

  wire full      = (level == LW'(DEPTH));
  wire fifo_rst  = wr & (widx == W_FCTL) & bus_wdata[1];
  wire push_req  = wr & (widx == W_WDAT);
  wire push      = push_req & ~full & ~fifo_rst;
  wire drop      = push_req & full;
  wire pop       = tx_ready & tx_en & (level != '0) & ~fifo_rst;
  wire rx_take   = rx_valid & rx_en;

  assign lvl_next = level + LW'(push) - LW'(pop);
  assign thr      = (thr_code > 3'd4) ? LW'(16) : (LW'(1) << thr_code);

  wire wm_set    = push & (lvl_next >= thr);
  wire wm_clr    = pop & (lvl_next < thr);
  wire empty_set = pop & (lvl_next == '0);

  assign events = {rx_take & ~rx_empty, empty_set, rx_take, wm_set};
  assign tst    = (wr && widx == W_TEST)  ? bus_wdata[3:0] : 4'h0;
  assign clr    = ((wr && widx == W_STATE) ? bus_wdata[3:0] : 4'h0) | {3'b000, wm_clr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_st   <= '0;
      int_en   <= '0;
      tx_en    <= 1'b0;
      rx_en    <= 1'b0;
      thr_code <= '0;
      tx_ovf   <= 1'b0;
    end else begin
      int_st <= (int_st & ~clr) | events | tst;
      if (wr && widx == W_EN) int_en <= bus_wdata[3:0];
      if (wr && widx == W_CTRL) begin
        tx_en <= bus_wdata[0];
        rx_en <= bus_wdata[1];
      end
      if (wr && widx == W_FCTL) thr_code <= bus_wdata[6:4];
      if (fifo_rst) tx_ovf <= 1'b0;
      else if (drop) tx_ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level  <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else if (fifo_rst) begin
      level  <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      level <= lvl_next;
      if (push) wr_ptr <= wr_ptr + PW'(1);
      if (pop)  rd_ptr <= rd_ptr + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_empty <= 1'b1;
      rx_idle  <= 1'b1;
    end else if (rx_take) begin
      rx_data  <= rx_byte;
      rx_empty <= 1'b0;
      rx_idle  <= 1'b0;
    end else if (rd && widx == W_RDAT && rx_en) begin
      rx_empty <= 1'b1;
      rx_idle  <= 1'b1;
    end
  end

  wire tx_mt = (level == '0);

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (widx)
        W_STATE: bus_rdata = {28'b0, int_st};
        W_EN:    bus_rdata = {28'b0, int_en};
        W_CTRL:  bus_rdata = {30'b0, rx_en, tx_en};
        W_STAT:  bus_rdata = {25'b0, tx_ovf, rx_empty, rx_idle, tx_mt, tx_mt, ~rx_empty, full};
        W_RDAT:  bus_rdata = {24'b0, rx_data};
        W_FCTL:  bus_rdata = {25'b0, thr_code, 4'b0};
        W_FSTAT: bus_rdata = 32'(level);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign tx_data      = mem[rd_ptr];
  assign tx_avail     = ~tx_mt & tx_en;
  assign irq_tx_wm    = int_st[0] & int_en[0];
  assign irq_rx_wm    = int_st[1] & int_en[1];
  assign irq_tx_empty = int_st[2] & int_en[2];
  assign irq_rx_ovf   = int_st[3] & int_en[3];
endmodule

module uart_regbank_chk #(
  parameter int DEPTH = 32,
  parameter int AW    = 10,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          rx_valid,
  input logic          rx_en,
  input logic          tx_en,
  input logic          rx_empty,
  input logic [LW-1:0] level,
  input logic [3:0]    int_st,
  input logic          irq_tx_wm,
  input logic          irq_rx_wm,
  input logic          irq_tx_empty,
  input logic          irq_rx_ovf
);
  wire wr_en   = bus_req && bus_we && bus_addr == AW'(4);
  wire wr_test = bus_req && bus_we && bus_addr == AW'(8);
  wire wr_st   = bus_req && bus_we && bus_addr == AW'(0);
  wire wr_frst = bus_req && bus_we && bus_addr == AW'(28) && bus_wdata[1];

  AST_EN_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_wdata[3:0] == 4'h0) |=> !(irq_tx_wm || irq_rx_wm || irq_tx_empty || irq_rx_ovf)); // R1
  AST_TEST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_test && bus_wdata[0]) |=> int_st[0]); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && bus_wdata[1] && !(rx_valid && rx_en)) |=> !int_st[1]); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R4
  AST_HOLD_NO_TXEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !wr_frst) |=> level >= $past(level)); // R11
  AST_RX_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_en) |=> !rx_empty); // R9
endmodule

bind uart_regbank uart_regbank_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rx_valid(rx_valid),
  .rx_en(rx_en), .tx_en(tx_en), .rx_empty(rx_empty), .level(level),
  .int_st(int_st), .irq_tx_wm(irq_tx_wm), .irq_rx_wm(irq_rx_wm),
  .irq_tx_empty(irq_tx_empty), .irq_rx_ovf(irq_rx_ovf)
);

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rx_valid = 1'b0, tx_ready = 1'b0, tx_avail;
  logic [7:0] rx_byte = '0, tx_data;
  logic irq_tx_wm, irq_rx_wm, irq_tx_empty, irq_rx_ovf;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_avail(tx_avail), .irq_tx_wm(irq_tx_wm),
    .irq_rx_wm(irq_rx_wm), .irq_tx_empty(irq_tx_empty), .irq_rx_ovf(irq_rx_ovf)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_req = 0;
  endtask

  task automatic pulse_tx();
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  task automatic send_rx(logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  function automatic logic [31:0] irqs();
    return {28'b0, irq_rx_ovf, irq_tx_empty, irq_rx_wm, irq_tx_wm};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(10'h10, v); chk("R3 status", v, 32'h3C);
    rd(10'h00, v); chk("R3 int state", v, 0);
    rd(10'h0C, v); chk("R3 ctrl", v, 0);
    rd(10'h20, v); chk("R3 fifo status", v, 0);
    chk("R3 irqs", irqs(), 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(10'h04, 32'hF); wr(10'h08, 32'hF);
    rd(10'h00, v); chk("R2 test sets", v, 32'hF);
    chk("R1 all lines", irqs(), 32'hF);
    wr(10'h00, 32'h5);
    rd(10'h00, v); chk("R2 w1c", v, 32'hA);
    chk("R1 partial", irqs(), 32'hA);
    wr(10'h04, 32'h2);
    chk("R1 gated", irqs(), 32'h2);
    wr(10'h00, 32'hF); wr(10'h04, 32'h0);
    rd(10'h00, v); chk("R2 cleared", v, 0);
  endtask

  task automatic t_fill_drain();
    logic [31:0] v;
    wr(10'h1C, 32'h30);
    for (int i = 0; i < 7; i++) wr(10'h18, 32'h10 + i);
    rd(10'h00, v); chk("R5 below thr", v & 1, 0);
    wr(10'h18, 32'h17);
    rd(10'h00, v); chk("R5 at thr", v & 1, 1);
    rd(10'h20, v); chk("R8 level 8", v, 8);
    for (int i = 8; i < 32; i++) wr(10'h18, 32'h10 + i);
    rd(10'h20, v); chk("R8 level 32", v, 32);
    wr(10'h18, 32'hEE);
    rd(10'h20, v); chk("R4 drop keeps 32", v, 32);
    rd(10'h10, v); chk("R4 R6 full and ovf status", v, 32'h71);
    pulse_tx();
    rd(10'h20, v); chk("R11 no drain when off", v, 32);
    wr(10'h0C, 32'h1);
    for (int i = 0; i < 32; i++) begin
      chk("R11 order", {24'b0, tx_data}, 32'h10 + i);
      pulse_tx();
      if (i == 23) begin rd(10'h00, v); chk("R5 still set at 8", v & 1, 1); end
      if (i == 24) begin rd(10'h00, v); chk("R5 cleared below", v & 1, 0); end
    end
    rd(10'h00, v); chk("R6 empty int", v & 4, 4);
    rd(10'h10, v); chk("R6 empty status", v, 32'h7C);
    pulse_tx();
    rd(10'h20, v); chk("R11 empty no pop", v, 0);
    wr(10'h0C, 32'h0); wr(10'h00, 32'hF);
  endtask

  task automatic t_fifo_reset();
    logic [31:0] v;
    for (int i = 0; i < 3; i++) wr(10'h18, i);
    rd(10'h20, v); chk("R8 level 3", v, 3);
    wr(10'h1C, 32'h32);
    rd(10'h20, v); chk("R7 emptied", v, 0);
    rd(10'h10, v); chk("R7 ovf cleared", v, 32'h3C);
    rd(10'h1C, v); chk("R5 thr kept", v, 32'h30);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    send_rx(8'h5A);
    rd(10'h10, v); chk("R9 ignored status", v, 32'h3C);
    rd(10'h14, v); chk("R9 ignored data", v, 0);
    wr(10'h0C, 32'h2);
    send_rx(8'hA5);
    rd(10'h10, v); chk("R9 status", v, 32'h0E);
    rd(10'h00, v); chk("R9 rx wm only", v, 32'h2);
    send_rx(8'h3C);
    rd(10'h00, v); chk("R9 overflow", v, 32'hA);
    rd(10'h14, v); chk("R10 data", v, 32'h3C);
    rd(10'h10, v); chk("R10 status after read", v, 32'h3C);
    send_rx(8'h77);
    wr(10'h0C, 32'h0);
    rd(10'h14, v); chk("R10 data disabled", v, 32'h77);
    rd(10'h10, v); chk("R10 no status change", v, 32'h0E);
    wr(10'h00, 32'hF);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(10'h04, 32'h3);
    wr(10'h3FC, 32'hFFFF_FFFF);
    rd(10'h3FC, v); chk("R12 unmapped read", v, 0);
    wr(10'h10, 32'hFF);
    rd(10'h10, v); chk("R12 status ro", v, 32'h0E);
    rd(10'h08, v); chk("R12 test wo", v, 0);
    rd(10'h18, v); chk("R12 wdata wo", v, 0);
    rd(10'h20, v); chk("R12 wdata read no push", v, 0);
    wr(10'h06, 32'hF);
    rd(10'h04, v); chk("R12 misaligned write", v, 3);
    wr(10'h1A, 32'h55);
    rd(10'h20, v); chk("R12 misaligned push", v, 0);
    rd(10'h05, v); chk("R12 misaligned read", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_irq();
    t_fill_drain();
    t_fifo_reset();
    t_rx();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule